// File: doc/BRIEF.md
# Serial Stepped-Attenuator Control Front End

This block is the digital control side of a two-channel stepped audio attenuator. A host drives a three-wire serial link: a serial clock, an active-low enable that opens the shift window, and a data line. While the enable is low, each rising serial-clock edge moves one bit into a 16-bit shift register. The bit that leaves the top of the register is driven on a data-out pin, so several of these blocks can share one data line in a chain.

When the enable returns high, the captured word is decoded. The upper byte selects a channel and the lower byte is that channel's step code. A word whose channel byte is not recognised leaves both channels as they were. Each channel turns its stored code into an attenuation figure, counted in half-dB units, and a mute flag. The law has two segments: fine half-dB steps, then whole-dB steps, then mute.

The serial pins are treated as asynchronous. They are resynchronised into the system clock `clk_i`, which must run several times faster than the serial clock.

Top module: `atten_ctrl`

## Requirements
- R1: While `load_ni` is low, each rising edge of `sclk_i` shifts `sdi_i` into bit 0 of a 16-bit register, so the word arrives MSB first. Bits 15:8 are the channel address and bits 7:0 are the step code.
- R2: Edges on `sclk_i` while `load_ni` is high leave the shift register unchanged.
- R3: `sdo_o` takes the register's bit 15 on each falling edge of `sclk_i`. A word shifted in therefore reappears on `sdo_o`, MSB first, during the next 16 serial clocks.
- R4: On a low-to-high transition of `load_ni`, address 0x00 loads the step code into channel 1 and address 0x01 loads it into channel 2.
- R5: Any other address value leaves both channels' outputs unchanged.
- R6: Step codes 0 to 95 give `mute_o` low and an attenuation equal to the code, in half-dB units (0 to 47.5 dB).
- R7: Step codes 96 to 126 give `mute_o` low and an attenuation of 2*code-96 half-dB units (48 dB to 78 dB in 1 dB steps).
- R8: Step codes 127 to 255 set the channel's `mute_o` bit and drive its attenuation field to 0.
- R9: While `rst_ni` is low, both channels are muted, the shift register is cleared and `sdo_o` is 0.
- R10: Channel 1 is `att_o[7:0]` / `mute_o[0]` and channel 2 is `att_o[15:8]` / `mute_o[1]`. Each updates within SYNC_STAGES+3 `clk_i` cycles of the enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| load_ni | input | 1 | Active-low shift enable; its rising edge applies the word |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out to the next device in a chain |
| att_o | output | 16 | Per-channel attenuation in half-dB units, 8 bits per channel |
| mute_o | output | 2 | Per-channel mute flag |

## Verification
The word table sends codes on both sides of each segment edge (0, 95, 96, 97, 126, 127, 255), so an off-by-one in either comparison or in the whole-dB slope shows up as a wrong count. Words with the address bytes 0x02 and 0x80 show whether the whole address byte is compared or only its low bit. A 32-bit stream in one enable window shows the chained data-out: the previous word and then the first new word must come back in order. Serial clocks sent with the enable high, followed by an empty enable pulse, show whether shifting is really gated by the enable.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int unsigned ADDR_W       = 8;
  localparam int unsigned CODE_W       = 8;
  localparam int unsigned WORD_W       = ADDR_W + CODE_W;
  localparam int unsigned ATT_W        = 8;
  localparam int unsigned FINE_CODES   = 96;  // half-dB segment length
  localparam int unsigned COARSE_CODES = 31;  // whole-dB segment length
  localparam int unsigned MUTE_CODE    = FINE_CODES + COARSE_CODES;

  typedef struct packed {
    logic             mute;
    logic [ATT_W-1:0] att;
  } step_out_t;

  function automatic step_out_t step_decode(input logic [CODE_W-1:0] code);
    step_out_t r;
    if (code < CODE_W'(FINE_CODES)) begin
      r.mute = 1'b0;
      r.att  = ATT_W'(code);
    end else if (code < CODE_W'(MUTE_CODE)) begin
      r.mute = 1'b0;
      r.att  = ATT_W'({code, 1'b0}) - ATT_W'(FINE_CODES);
    end else begin
      r.mute = 1'b1;
      r.att  = '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/atten_sync_edge.sv
module atten_sync_edge #(
  parameter int unsigned    STAGES  = 2,
  parameter int unsigned    W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/atten_shift_chain.sv
module atten_shift_chain #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic              launch_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] word_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sdo_q  <= 1'b0;
    end else begin
      if (shift_en_i) word_q <= {word_q[WORD_W-2:0], bit_i};
      // launched on serial falling edge, stable for next device's rising edge
      if (launch_i) sdo_q <= word_q[WORD_W-1];
    end
  end

  assign word_o = word_q;
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/atten_chan.sv
module atten_chan
  import atten_pkg::*;
#(
  parameter int unsigned CH_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [ATT_W-1:0]  att_o,
  output logic              mute_o
);
  logic [CODE_W-1:0] code_q;
  step_out_t         dec;
  logic              hit;

  assign hit = (word_i[WORD_W-1 -: ADDR_W] == ADDR_W'(CH_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            code_q <= '1;
    else if (apply_i && hit) code_q <= word_i[CODE_W-1:0];
  end

  assign dec    = step_decode(code_q);
  assign att_o  = dec.att;
  assign mute_o = dec.mute;
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
#(
  parameter int unsigned N_CH        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  load_ni,
  input  logic                  sdi_i,
  output logic                  sdo_o,
  output logic [N_CH*ATT_W-1:0] att_o,
  output logic [N_CH-1:0]       mute_o
);
  localparam int unsigned PIN_W = 3;
  localparam int unsigned P_SCLK = 0;
  localparam int unsigned P_LOAD = 1;
  localparam int unsigned P_SDI  = 2;

  logic [PIN_W-1:0]  pin_lvl, pin_rise, pin_fall;
  logic              shift_en, apply;
  logic [WORD_W-1:0] word_q;

  atten_sync_edge #(
    .STAGES (SYNC_STAGES),
    .W      (PIN_W),
    .RST_VAL(PIN_W'(1) << P_LOAD)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdi_i, load_ni, sclk_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign shift_en = pin_rise[P_SCLK] & ~pin_lvl[P_LOAD];
  assign apply    = pin_rise[P_LOAD];

  atten_shift_chain #(.WORD_W(WORD_W)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .bit_i      (pin_lvl[P_SDI]),
    .launch_i   (pin_fall[P_SCLK]),
    .word_o     (word_q),
    .sdo_o      (sdo_o)
  );

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_ch
    atten_chan #(.CH_ADDR(g)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .apply_i (apply),
      .word_i  (word_q),
      .att_o   (att_o[g*ATT_W +: ATT_W]),
      .mute_o  (mute_o[g])
    );
  end
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk
  import atten_pkg::*;
#(
  parameter int unsigned N_CH = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  shift_en,
  input logic                  apply,
  input logic                  sclk_fall,
  input logic                  sdi_lvl,
  input logic [WORD_W-1:0]     word_q,
  input logic                  sdo_o,
  input logic [N_CH*ATT_W-1:0] att_o,
  input logic [N_CH-1:0]       mute_o
);
  localparam logic [ATT_W-1:0] ATT_MAX = ATT_W'(2 * (MUTE_CODE - 1) - FINE_CODES);

  a_r1_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> word_q[0] == $past(sdi_lvl));

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable(word_q));

  a_r3_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(sdo_o));

  a_r5_hold_no_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> $stable(att_o) && $stable(mute_o));

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_chk
    a_r8_mute_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mute_o[g] |-> att_o[g*ATT_W +: ATT_W] == '0);
    a_r7_att_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mute_o[g] |-> att_o[g*ATT_W +: ATT_W] <= ATT_MAX);
  end
endmodule

bind atten_ctrl atten_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shift_en  (shift_en),
  .apply     (apply),
  .sclk_fall (pin_fall[P_SCLK]),
  .sdi_lvl   (pin_lvl[P_SDI]),
  .word_q    (word_q),
  .sdo_o     (sdo_o),
  .att_o     (att_o),
  .mute_o    (mute_o)
);

// File: tb/atten_ctrl_bench.sv
module atten_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0;
  logic        load_n = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [15:0] att;
  logic [1:0]  mute;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  atten_ctrl u_atten_ctrl (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sclk_i (sclk),
    .load_ni(load_n),
    .sdi_i  (sdi),
    .sdo_o  (sdo),
    .att_o  (att),
    .mute_o (mute)
  );

  // {word, ch1 att, ch1 mute, ch2 att, ch2 mute} after each word
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {16'h0000, 8'd0,  1'b0, 8'd0,   1'b1},  // R4 R6 code 0
    {16'h0160, 8'd0,  1'b0, 8'd96,  1'b0},  // R7 code 96
    {16'h005F, 8'd95, 1'b0, 8'd96,  1'b0},  // R6 code 95
    {16'h017E, 8'd95, 1'b0, 8'd156, 1'b0},  // R7 code 126
    {16'h007F, 8'd0,  1'b1, 8'd156, 1'b0},  // R8 code 127
    {16'h0261, 8'd0,  1'b1, 8'd156, 1'b0},  // R5 addr 2
    {16'h0161, 8'd0,  1'b1, 8'd98,  1'b0},  // R7 code 97
    {16'h00FF, 8'd0,  1'b1, 8'd98,  1'b0},  // R8 code 255
    {16'h0001, 8'd1,  1'b0, 8'd98,  1'b0},  // R6 code 1
    {16'h8001, 8'd1,  1'b0, 8'd98,  1'b0},  // R5 addr 0x80
    {16'h0128, 8'd1,  1'b0, 8'd40,  1'b0},  // R4 ch2
    {16'h0060, 8'd96, 1'b0, 8'd40,  1'b0}   // R7 ch1 code 96
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic seen);
    @(negedge clk) sdi = b;
    repeat (3) @(negedge clk);
    seen = sdo;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int nbits, output logic [31:0] seen);
    logic s;
    seen = '0;
    @(negedge clk) load_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sbit(w[nbits-1-i], s);
      seen = {seen[30:0], s};
    end
    repeat (4) @(negedge clk);
    load_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] seen;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 mute", {30'd0, mute}, 32'h3);
    check("R9 att", {16'd0, att}, 32'h0);
    check("R9 sdo", {31'd0, sdo}, 32'h0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      send({16'd0, VEC[v][33:18]}, 16, seen);
      check($sformatf("R10 ch1 att v%0d", v), {24'd0, att[7:0]},  {24'd0, VEC[v][17:10]});
      check($sformatf("R10 ch1 mute v%0d", v), {31'd0, mute[0]}, {31'd0, VEC[v][9]});
      check($sformatf("R10 ch2 att v%0d", v), {24'd0, att[15:8]}, {24'd0, VEC[v][8:1]});
      check($sformatf("R10 ch2 mute v%0d", v), {31'd0, mute[1]}, {31'd0, VEC[v][0]});
    end

    // R3 chained data-out: previous word then first new word come out MSB first
    send({16'h0055, 16'h0107}, 32, seen);
    check("R3 sdo old word", {16'd0, seen[31:16]}, 32'h0060);
    check("R3 sdo first word", {16'd0, seen[15:0]}, 32'h0055);
    check("R1 last word applied ch2", {24'd0, att[15:8]}, 32'd7);
    check("R1 first word not applied ch1", {24'd0, att[7:0]}, 32'd96);

    // R2 clocks with enable high must not shift
    send(32'h000A, 16, seen);
    send(32'h0100, 16, seen);
    check("R6 ch1 code 10", {24'd0, att[7:0]}, 32'd10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) sdi = 1'b0;
      repeat (2) @(negedge clk) sclk = 1'b1;
      repeat (3) @(negedge clk) sclk = 1'b0;
    end
    send(32'h0, 0, seen);
    check("R2 ch1 kept", {24'd0, att[7:0]}, 32'd10);
    check("R2 ch2 reapplied", {23'd0, mute[1], att[15:8]}, 32'd0);

    // R9 reset after activity
    @(negedge clk) rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 mute again", {30'd0, mute}, 32'h3);
    check("R9 att again", {16'd0, att}, 32'h0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    send(32'h0105, 16, seen);
    check("R9 cleared register", seen, 32'h0);
    check("R8 ch1 still muted", {31'd0, mute[0]}, 32'h1);
    check("R6 ch2 code 5", {24'd0, att[15:8]}, 32'd5);
    finish_run();
  end
endmodule